// File: doc/BRIEF.md
# Majority-Clocked Keystream Generator

This block turns a 64-bit secret key and a 22-bit frame number into 228 keystream bits. It holds three linear feedback shift registers of 19, 22 and 23 bits. After a start request it first mixes the key and frame number into the registers, one bit per cycle, with every register stepping. It then runs a mixing phase in which each register steps only when its own clocking tap agrees with the majority of the three taps. The output of this phase is thrown away. Finally it emits 228 bits, one per cycle, each being the XOR of the three register MSBs.

The first 114 emitted bits form the downlink block and the last 114 bits form the uplink block. An `ks_up` flag marks the uplink block. The caller pulses `start` while the block is idle and collects bits whenever `ks_valid` is high. A single-cycle `done` pulse marks the last bit. The whole run takes 414 cycles.

Top module: `kg_keystream`

## Requirements
- R1: While `rst` is high, and in the cycle after it has been high, `busy`, `ks_valid`, `ks_up` and `done` are 0. A reset during a run aborts it. Afterwards the block accepts a new start and produces a correct stream.
- R2: A `start` seen while idle clears all three registers and captures `key` and `count`. It then performs 86 loading steps. Seed bit i is `key[i]` for i < 64 and `count[i-64]` otherwise. In each loading step all three registers step, and the seed bit is XORed into each feedback bit.
- R3: The registers are 19, 22 and 23 bits wide. A step shifts a register toward its MSB, with the feedback bit entering bit 0. The feedback bits are:
  - first register: XOR of bits 13, 16, 17 and 18;
  - second register: XOR of bits 20 and 21;
  - third register: XOR of bits 7, 20, 21 and 22.
- R4: After loading, each step uses the clocking taps: bit 8 of the first register, bit 10 of the second and bit 10 of the third. A register steps only when its tap equals the majority value of the three taps taken before the step. At least two registers step on every such step; a register that does not step keeps its value.
- R5: The first 100 majority-clocked steps produce no output. The first `ks_valid` appears 187 cycles after the clock edge that accepted `start`.
- R6: The next 228 steps each produce one bit on `ks_bit` with `ks_valid` high, in consecutive cycles 187 to 414 after the start edge. Each bit is the XOR of the three MSBs after that step.
- R7: `ks_up` is 0 for the first 114 valid bits and 1 for the last 114 bits.
- R8: `done` is high for exactly one cycle, together with the 228th valid bit. `busy` is already 0 in that cycle.
- R9: A `start` while `busy` is ignored. Changes on `key` or `count` after the start edge do not alter the stream.
- R10: An all-zero key and count give 228 zero bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run (honoured only when idle) |
| key | input | 64 | Secret key, bit 0 loaded first |
| count | input | 22 | Frame number, loaded after the key, bit 0 first |
| ks_bit | output | 1 | Keystream bit |
| ks_valid | output | 1 | `ks_bit` carries a kept bit |
| ks_up | output | 1 | Current bit belongs to the uplink block |
| done | output | 1 | Pulse with the final bit |
| busy | output | 1 | A run is in progress |

## Verification
The bench compares every emitted bit with a bit-array model of its own, using several keys and counts.

- An all-zero seed catches a design that never clears its registers: it would emit ones.
- An off-by-one in the discard count shifts the whole stream and moves the first valid bit away from cycle 187.
- A mistaken seed bit order or tap position corrupts the stream within a few bits.
- A second `start` with a changed key in mid-run exposes a design that restarts, or that reads the key live instead of the captured copy.
- A mid-run reset shows whether the run is really aborted.
- A wrong block split or a badly placed `done` shows up in the `ks_up` and `done` timing checks.

// File: rtl/kg_pkg.sv
package kg_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LOAD,
    PH_WARM,
    PH_KEEP
  } kg_phase_e;

  // value held by at least two of the three inputs
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // a register may step when in regular mode or when its tap sides with the majority
  function automatic logic may_step(input logic regular, input logic tap, input logic vote);
    return regular | (tap == vote);
  endfunction

endpackage

// File: rtl/kg_lfsr.sv
module kg_lfsr #(
  parameter int unsigned W     = 19,
  parameter logic [W-1:0] TAPS = '0,
  parameter int unsigned CTAP  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic adv,
  input  logic inj,
  output logic ctap,
  output logic msb_nxt
);

  logic [W-1:0] q;
  logic         fb;

  assign fb = (^(q & TAPS)) ^ inj;

  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (adv)   q <= {q[W-2:0], fb};
  end

  assign ctap    = q[CTAP];
  assign msb_nxt = adv ? q[W-2] : q[W-1];

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!adv && !clr) |=> $stable(q));

endmodule

// File: rtl/kg_clkctl.sv
module kg_clkctl (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       regular,
  input  logic [2:0] taps,
  output logic [2:0] step_en
);
  import kg_pkg::*;

  logic vote;
  assign vote = maj3(taps[0], taps[1], taps[2]);

  for (genvar g = 0; g < 3; g++) begin : g_en
    assign step_en[g] = run & may_step(regular, taps[g], vote);
  end

  // R4
  maj_two_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !regular) |-> ($countones(step_en) >= 2));

  // R2
  load_all_chk: assert property (@(posedge clk) disable iff (rst)
    (run && regular) |-> (step_en == 3'b111));

  // R2
  idle_still_chk: assert property (@(posedge clk) disable iff (rst)
    !run |-> (step_en == 3'b000));

endmodule

// File: rtl/kg_seq.sv
module kg_seq #(
  parameter int unsigned KEY_W  = 64,
  parameter int unsigned CNT_W  = 22,
  parameter int unsigned WARM_N = 100,
  parameter int unsigned KEEP_N = 228
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [KEY_W-1:0] key,
  input  logic [CNT_W-1:0] count,
  output logic             clr,
  output logic             run,
  output logic             regular,
  output logic             inj,
  output logic             emit,
  output logic             last,
  output logic             upper,
  output logic             busy
);
  import kg_pkg::*;

  localparam int unsigned SEED_W = KEY_W + CNT_W;
  localparam int unsigned CTR_W  = $clog2(max3(SEED_W, WARM_N, KEEP_N) + 1);

  kg_phase_e         phase;
  logic [CTR_W-1:0]  ctr;
  logic [SEED_W-1:0] seed;
  logic              load_end, warm_end;

  assign load_end = (phase == PH_LOAD) && (ctr == CTR_W'(SEED_W - 1));
  assign warm_end = (phase == PH_WARM) && (ctr == CTR_W'(WARM_N - 1));
  assign last     = (phase == PH_KEEP) && (ctr == CTR_W'(KEEP_N - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      ctr   <= '0;
      seed  <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_LOAD;
          ctr   <= '0;
          seed  <= {count, key};
        end
        PH_LOAD: begin
          ctr <= load_end ? '0 : ctr + 1'b1;
          if (load_end) phase <= PH_WARM;
        end
        PH_WARM: begin
          ctr <= warm_end ? '0 : ctr + 1'b1;
          if (warm_end) phase <= PH_KEEP;
        end
        PH_KEEP: begin
          ctr <= last ? '0 : ctr + 1'b1;
          if (last) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign busy    = (phase != PH_IDLE);
  assign clr     = (phase == PH_IDLE) && start;
  assign run     = busy;
  assign regular = (phase == PH_LOAD);
  assign inj     = regular ? seed[ctr] : 1'b0;
  assign emit    = (phase == PH_KEEP);
  assign upper   = emit && (ctr >= CTR_W'(KEEP_N / 2));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !last) |=> busy);

  // R9
  seed_keep_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(seed));

  // R5
  warm_to_keep_chk: assert property (@(posedge clk) disable iff (rst)
    warm_end |=> (emit && ctr == '0));

endmodule

// File: rtl/kg_keystream.sv
module kg_keystream #(
  parameter int unsigned KEY_W   = 64,
  parameter int unsigned CNT_W   = 22,
  parameter int unsigned WARM_N  = 100,
  parameter int unsigned KEEP_N  = 228,
  parameter int unsigned A_W     = 19,
  parameter int unsigned B_W     = 22,
  parameter int unsigned C_W     = 23,
  parameter logic [31:0] A_TAPS  = 32'h0007_2000,
  parameter logic [31:0] B_TAPS  = 32'h0030_0000,
  parameter logic [31:0] C_TAPS  = 32'h0070_0080,
  parameter int unsigned A_CT    = 8,
  parameter int unsigned B_CT    = 10,
  parameter int unsigned C_CT    = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [KEY_W-1:0] key,
  input  logic [CNT_W-1:0] count,
  output logic             ks_bit,
  output logic             ks_valid,
  output logic             ks_up,
  output logic             done,
  output logic             busy
);

  localparam int unsigned  WID  [3] = '{A_W, B_W, C_W};
  localparam logic [31:0]  TAPM [3] = '{A_TAPS, B_TAPS, C_TAPS};
  localparam int unsigned  CTP  [3] = '{A_CT, B_CT, C_CT};

  logic       clr, run, regular, inj, emit, last, upper;
  logic [2:0] taps, step_en, nxt;

  kg_seq #(
    .KEY_W(KEY_W), .CNT_W(CNT_W), .WARM_N(WARM_N), .KEEP_N(KEEP_N)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .key(key), .count(count),
    .clr(clr), .run(run), .regular(regular), .inj(inj),
    .emit(emit), .last(last), .upper(upper), .busy(busy)
  );

  kg_clkctl u_ctl (
    .clk(clk), .rst(rst), .run(run), .regular(regular),
    .taps(taps), .step_en(step_en)
  );

  for (genvar g = 0; g < 3; g++) begin : g_reg
    kg_lfsr #(
      .W(WID[g]), .TAPS(TAPM[g][WID[g]-1:0]), .CTAP(CTP[g])
    ) u_lfsr (
      .clk(clk), .rst(rst), .clr(clr), .adv(step_en[g]), .inj(inj),
      .ctap(taps[g]), .msb_nxt(nxt[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ks_bit   <= 1'b0;
      ks_valid <= 1'b0;
      ks_up    <= 1'b0;
      done     <= 1'b0;
    end else begin
      ks_bit   <= emit & (^nxt);
      ks_valid <= emit;
      ks_up    <= upper;
      done     <= last;
    end
  end

  // R6
  valid_src_chk: assert property (@(posedge clk) disable iff (rst)
    !emit |=> !ks_valid);

  // R8
  done_valid_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (ks_valid && ks_up && !busy));

  // R7
  up_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    ks_up |-> ks_valid);

endmodule

// File: tb/test_kg_keystream.sv
module test_kg_keystream;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [63:0] key = '0;
  logic [21:0] count = '0;
  logic        ks_bit, ks_valid, ks_up, done, busy;

  int n_checks = 0;
  int n_fails  = 0;

  always #4 clk = ~clk;

  kg_keystream i_kg_keystream (
    .clk(clk), .rst(rst), .start(start), .key(key), .count(count),
    .ks_bit(ks_bit), .ks_valid(ks_valid), .ks_up(ks_up),
    .done(done), .busy(busy)
  );

  localparam logic [85:0] VEC [4] = '{
    {22'h000134, 64'h1223_4567_89AB_CDEF},
    {22'h3FFFFF, 64'hFFFF_FFFF_FFFF_FFFF},
    {22'h000000, 64'h0000_0000_0000_0000},
    {22'h2A5A5A, 64'h8000_0000_0000_0001}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // independent bit-level model of the keystream
  function automatic logic [227:0] model(input logic [63:0] k, input logic [21:0] c);
    logic [18:0]  a;
    logic [21:0]  b;
    logic [22:0]  d;
    logic [227:0] o;
    logic inb, m, fa, fb, fd;
    a = '0; b = '0; d = '0; o = '0;
    for (int i = 0; i < 86; i++) begin
      if (i < 64) inb = k[i];
      else        inb = c[i-64];
      fa = a[18] ^ a[17] ^ a[16] ^ a[13] ^ inb;
      fb = b[21] ^ b[20] ^ inb;
      fd = d[22] ^ d[21] ^ d[20] ^ d[7] ^ inb;
      a = {a[17:0], fa};
      b = {b[20:0], fb};
      d = {d[21:0], fd};
    end
    for (int i = 0; i < 328; i++) begin
      m  = (a[8] & b[10]) | (a[8] & d[10]) | (b[10] & d[10]);
      fa = a[18] ^ a[17] ^ a[16] ^ a[13];
      fb = b[21] ^ b[20];
      fd = d[22] ^ d[21] ^ d[20] ^ d[7];
      if (a[8] == m)  a = {a[17:0], fa};
      if (b[10] == m) b = {b[20:0], fb};
      if (d[10] == m) d = {d[21:0], fd};
      if (i >= 100) o[i-100] = a[18] ^ b[21] ^ d[22];
    end
    return o;
  endfunction

  // poke_at > 0: at that cycle pulse start again and change key/count (R9)
  task automatic run_vec(input logic [63:0] k, input logic [21:0] c, input int poke_at);
    logic [227:0] exp;
    int nbits, first, done_at, done_cnt;
    exp = model(k, c);
    nbits = 0; first = -1; done_at = -1; done_cnt = 0;
    @(negedge clk);
    key = k; count = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 1; n <= 420; n++) begin
      @(negedge clk);
      start = 1'b0;
      if (ks_valid) begin
        if (first < 0) first = n;
        if (nbits < 228) begin
          chk(ks_bit == exp[nbits], "R2/R3/R4/R6/R9 keystream bit", ks_bit, exp[nbits]);
          chk(ks_up == (nbits >= 114), "R7 block flag", ks_up, (nbits >= 114));
        end
        nbits++;
      end
      if (done) begin
        done_at = n;
        done_cnt++;
        chk(busy == 1'b0, "R8 busy low with done", busy, 0);
      end
      if (n == poke_at) begin
        start = 1'b1; key = ~k; count = ~c;
      end
    end
    chk(first == 187, "R5 first valid cycle", first, 187);
    chk(nbits == 228, "R6 kept bit count", nbits, 228);
    chk(done_at == 414, "R8 done cycle", done_at, 414);
    chk(done_cnt == 1, "R8 done pulse count", done_cnt, 1);
    chk(busy == 1'b0, "R8 idle after run", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [227:0] z;
    repeat (3) @(negedge clk);
    chk({busy, ks_valid, ks_up, done} == 4'b0, "R1 outputs in reset",
        {busy, ks_valid, ks_up, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({busy, ks_valid, ks_up, done} == 4'b0, "R1 outputs after reset",
        {busy, ks_valid, ks_up, done}, 0);

    // R10: all-zero seed must give an all-zero stream
    z = model(64'h0, 22'h0);
    chk(z == '0, "R10 model zero stream", (z != '0), 0);

    for (int v = 0; v < 4; v++) run_vec(VEC[v][63:0], VEC[v][85:64], 0);

    // R9: restart attempts and input changes in mid-run are ignored
    run_vec(64'h0F1E_2D3C_4B5A_6978, 22'h15A3C0, 40);
    run_vec(64'hDEAD_BEEF_0123_4567, 22'h0ABCDE, 250);

    // R1: reset in mid-run aborts the run
    @(negedge clk);
    key = 64'h5555_AAAA_3333_CCCC; count = 22'h1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (200) @(negedge clk);
    chk(ks_valid == 1'b1, "R1 run active before reset", ks_valid, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({busy, ks_valid, ks_up, done} == 4'b0, "R1 mid-run reset aborts",
        {busy, ks_valid, ks_up, done}, 0);
    repeat (5) @(negedge clk);
    chk(busy == 1'b0, "R1 stays idle after reset", busy, 0);
    run_vec(64'h5555_AAAA_3333_CCCC, 22'h1, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule